// File: doc/BRIEF.md
# Atomic Test-and-Set Bus Arbiter

This block shares one memory bus among several processors and makes a test-and-set on a memory word indivisible. Each processor raises its request with an operation, a word address and write data. It keeps them steady until it sees its completion pulse. The arbiter grants one processor at a time. A plain read or a plain write uses one granted bus cycle. A test-and-set uses two: a read cycle that returns the old word, then a write cycle that stores 1 into the same word.

The requester holds the grant across both cycles of a test-and-set by raising its lock line. No other processor can reach the bus between the read and the write. When two processors test-and-set the same free word at the same time, exactly one of them sees 0. A small word-addressed memory model sits behind the bus, so the whole exchange can be observed at the ports.

After each completed access the bus stays idle for one cycle. Arbitration happens at the end of that cycle, in round-robin order starting after the processor granted last.

Top module: `tas_bus_arbiter`

## Requirements
- R1: After reset no grant and no completion pulse is active, the read-data output is 0, and every memory word reads as 0.
- R2: A read (operation code 0 in bits [2k+1:2k] of `op_i` for processor k) gets one grant cycle. The grant starts on the first clock edge that sees the request while the bus is free. The completion pulse and the read word both appear one clock later.
- R3: A write (operation code 1) gets one grant cycle and stores that processor's `wdata_i` slice into the addressed word.
- R4: A test-and-set (operation code 2) with the lock line high in its first grant cycle keeps the same grant for exactly two cycles. It returns the old word on `rdata_o`, leaves the word equal to 1, and pulses completion after the second cycle.
- R5: A test-and-set whose lock line is low in its first grant cycle completes after that single cycle as a plain read and leaves the word unchanged.
- R6: Among simultaneous requesters the grant goes to the first one found when counting upward, with wraparound, from the processor granted last. After reset the search starts at processor 0.
- R7: At most one grant is active. A grant never moves straight from one processor to another. In the cycle a completion pulse is visible, no grant is active.
- R8: While a locked test-and-set is in progress no other processor is granted. Two contending test-and-sets on a word that holds 0 return 0 to exactly one of them and 1 to the other.
- R9: A lock line from a processor that holds no grant has no effect: it neither obtains the bus without a request nor lengthens another processor's access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CPU | Bus request per processor |
| lock_i | input | N_CPU | Lock line per processor |
| op_i | input | 2*N_CPU | Operation code per processor: 0 read, 1 write, 2 test-and-set |
| addr_i | input | N_CPU*ADDR_W | Word address per processor |
| wdata_i | input | N_CPU*DATA_W | Write data per processor |
| gnt_o | output | N_CPU | One-hot bus grant |
| done_o | output | N_CPU | One-cycle completion pulse per processor |
| rdata_o | output | DATA_W | Word returned by the latest read cycle |

## Verification
The properties assume each processor obeys the handshake. It holds its request, operation, address and lock steady from the request until its completion pulse. It then drops the request during the idle cycle that follows, and it never starts a grant without a request. The stimulus changes inputs only on the falling clock edge. Each processor's task releases its request in the same half-cycle in which it observes its completion pulse, so no held request is ever re-granted by accident. Lock lines are raised only together with a test-and-set, except in the scenario that drives a stray lock from a processor that is not requesting.

// File: rtl/tas_pkg.sv
package tas_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_TAS = 2'd2
  } bus_op_e;
endpackage

// File: rtl/tas_rr_pick.sv
module tas_rr_pick #(
  parameter int N_CPU = 4,
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic [N_CPU-1:0] req_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = last_i;
    for (int off = 1; off <= N_CPU; off++) begin
      int c;
      c = (int'(last_i) + off) % N_CPU;
      if (!valid_o && req_i[c]) begin
        valid_o = 1'b1;
        idx_o   = c[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tas_seq.sv
module tas_seq
  import tas_pkg::*;
#(
  parameter int N_CPU = 4,
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pick_valid_i,
  input  logic [IDX_W-1:0] pick_idx_i,
  input  bus_op_e          own_op_i,
  input  logic             own_lock_i,
  output logic [N_CPU-1:0] gnt_o,
  output logic [IDX_W-1:0] owner_o,
  output logic [IDX_W-1:0] last_o,
  output logic             mem_we_o,
  output logic             wr_one_o,
  output logic             rd_en_o,
  output logic [N_CPU-1:0] done_o
);
  logic [N_CPU-1:0] gnt_q, done_q;
  logic [IDX_W-1:0] owner_q, last_q;
  logic             phase_q;
  logic             busy, fin, hold;

  assign busy = |gnt_q;

  always_comb begin
    fin  = 1'b0;
    hold = 1'b0;
    if (busy) begin
      if (own_op_i == OP_TAS && !phase_q && own_lock_i) hold = 1'b1;
      else                                              fin  = 1'b1;
    end
  end

  assign mem_we_o = busy && (own_op_i == OP_WR || (own_op_i == OP_TAS && phase_q));
  assign wr_one_o = phase_q;
  assign rd_en_o  = busy && !phase_q && own_op_i != OP_WR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q   <= '0;
      done_q  <= '0;
      owner_q <= '0;
      last_q  <= IDX_W'(N_CPU - 1);
      phase_q <= 1'b0;
    end else begin
      done_q <= '0;
      if (!busy) begin
        if (pick_valid_i) begin
          gnt_q             <= '0;
          gnt_q[pick_idx_i] <= 1'b1;
          owner_q           <= pick_idx_i;
          last_q            <= pick_idx_i;
          phase_q           <= 1'b0;
        end
      end else if (fin) begin
        gnt_q           <= '0;
        phase_q         <= 1'b0;
        done_q[owner_q] <= 1'b1;
      end else if (hold) begin
        phase_q <= 1'b1;
      end
    end
  end

  assign gnt_o   = gnt_q;
  assign done_o  = done_q;
  assign owner_o = owner_q;
  assign last_o  = last_q;
endmodule

// File: rtl/tas_mem.sv
module tas_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i)    mem_q[addr_i] <= wdata_i;
      if (rd_en_i) rdata_q       <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/tas_bus_arbiter.sv
module tas_bus_arbiter
  import tas_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CPU-1:0]         req_i,
  input  logic [N_CPU-1:0]         lock_i,
  input  logic [2*N_CPU-1:0]       op_i,
  input  logic [N_CPU*ADDR_W-1:0]  addr_i,
  input  logic [N_CPU*DATA_W-1:0]  wdata_i,
  output logic [N_CPU-1:0]         gnt_o,
  output logic [N_CPU-1:0]         done_o,
  output logic [DATA_W-1:0]        rdata_o
);
  logic             pick_valid;
  logic [IDX_W-1:0] pick_idx, owner, last;
  logic             mem_we, wr_one, rd_en;
  bus_op_e          own_op;
  logic             own_lock;
  logic [ADDR_W-1:0] own_addr;
  logic [DATA_W-1:0] own_wdata, bus_wdata;

  // owner's lines steer the shared bus
  assign own_op    = bus_op_e'(op_i[owner*2 +: 2]);
  assign own_lock  = lock_i[owner];
  assign own_addr  = addr_i[owner*ADDR_W +: ADDR_W];
  assign own_wdata = wdata_i[owner*DATA_W +: DATA_W];
  assign bus_wdata = wr_one ? DATA_W'(1) : own_wdata;

  tas_rr_pick #(.N_CPU(N_CPU)) i_pick (
    .req_i   (req_i),
    .last_i  (last),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  tas_seq #(.N_CPU(N_CPU)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pick_valid_i (pick_valid),
    .pick_idx_i   (pick_idx),
    .own_op_i     (own_op),
    .own_lock_i   (own_lock),
    .gnt_o        (gnt_o),
    .owner_o      (owner),
    .last_o       (last),
    .mem_we_o     (mem_we),
    .wr_one_o     (wr_one),
    .rd_en_o      (rd_en),
    .done_o       (done_o)
  );

  tas_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .rd_en_i (rd_en),
    .addr_i  (own_addr),
    .wdata_i (bus_wdata),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/tas_bus_arbiter_chk.sv
module tas_bus_arbiter_chk
  import tas_pkg::*;
#(
  parameter int N_CPU = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CPU-1:0]   req_i,
  input logic [N_CPU-1:0]   lock_i,
  input logic [2*N_CPU-1:0] op_i,
  input logic [N_CPU-1:0]   gnt_o,
  input logic [N_CPU-1:0]   done_o
);
  // R7
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R7
  idle_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o != '0) |-> (gnt_o == '0));

  // R7
  no_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0 && $past(gnt_o) != '0) |-> (gnt_o == $past(gnt_o)));

  for (genvar k = 0; k < N_CPU; k++) begin : g_cpu
    // R2
    done_follows_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[k] |-> $past(gnt_o[k]));

    // R9
    gnt_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[k] && !$past(gnt_o[k])) |-> $past(req_i[k]));

    // R8
    lock_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[k] && !$past(gnt_o[k]) && op_i[2*k +: 2] == OP_TAS && lock_i[k])
        |=> (gnt_o[k] && done_o == '0));
  end
endmodule

bind tas_bus_arbiter tas_bus_arbiter_chk #(.N_CPU(N_CPU)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .lock_i (lock_i),
  .op_i   (op_i),
  .gnt_o  (gnt_o),
  .done_o (done_o)
);

// File: tb/test_tas_bus_arbiter.sv
module test_tas_bus_arbiter;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0, lock = '0;
  logic [2*N-1:0]  op = '0;
  logic [N*AW-1:0] addr = '0;
  logic [N*DW-1:0] wdata = '0;
  logic [N-1:0]    gnt, done;
  logic [DW-1:0]   rdata;

  int n_chk = 0, n_bad = 0;
  int ord [16];
  int ord_n = 0;
  logic [N-1:0] prev_g = '0;

  always #2 clk = ~clk;

  tas_bus_arbiter #(.N_CPU(N), .ADDR_W(AW), .DATA_W(DW)) i_tas_bus_arbiter (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .lock_i (lock), .op_i (op),
    .addr_i (addr), .wdata_i (wdata), .gnt_o (gnt), .done_o (done), .rdata_o (rdata)
  );

  // grant order log
  always @(negedge clk) begin
    if (gnt != '0 && gnt != prev_g) begin
      for (int i = 0; i < N; i++) if (gnt[i] && ord_n < 16) begin
        ord[ord_n] = i;
        ord_n++;
      end
    end
    prev_g = gnt;
  end

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // starts on a falling edge; returns data, cycles to done, grant cycles
  task automatic access(input int k, input int o, input int a, input int d, input bit lk,
                        output int rd, output int cyc, output int gc);
    cyc = 0; gc = 0;
    req[k] = 1'b1; lock[k] = lk;
    op[2*k +: 2] = 2'(o); addr[k*AW +: AW] = AW'(a); wdata[k*DW +: DW] = DW'(d);
    forever begin
      @(posedge clk); @(negedge clk);
      cyc++;
      if (gnt[k]) gc++;
      if (done[k]) break;
    end
    rd = int'(rdata);
    req[k] = 1'b0; lock[k] = 1'b0;
  endtask

  task automatic t_reset();
    int rd, cyc, gc;
    check(gnt == '0, "R1 gnt", int'(gnt), 0);
    check(done == '0, "R1 done", int'(done), 0);
    check(rdata == '0, "R1 rdata", int'(rdata), 0);
    access(0, 0, 5, 0, 0, rd, cyc, gc);
    check(rd == 0, "R1 memory word", rd, 0);
  endtask

  task automatic t_write_read();
    int rd, cyc, gc;
    access(1, 1, 3, 8'hA5, 0, rd, cyc, gc);
    check(cyc == 2, "R3 write latency", cyc, 2);
    check(gc == 1, "R3 write grant cycles", gc, 1);
    @(negedge clk);
    access(2, 0, 3, 0, 0, rd, cyc, gc);
    check(rd == 8'hA5, "R3 written word", rd, 8'hA5);
    check(cyc == 2, "R2 read latency", cyc, 2);
    check(gc == 1, "R2 read grant cycles", gc, 1);
  endtask

  task automatic t_tas_locked();
    int rd, cyc, gc;
    @(negedge clk);
    access(0, 2, 7, 0, 1, rd, cyc, gc);
    check(rd == 0, "R4 old word 0", rd, 0);
    check(cyc == 3, "R4 latency", cyc, 3);
    check(gc == 2, "R4 grant cycles", gc, 2);
    @(negedge clk);
    access(0, 0, 7, 0, 0, rd, cyc, gc);
    check(rd == 1, "R4 word set", rd, 1);
    @(negedge clk);
    access(3, 2, 3, 0, 1, rd, cyc, gc);
    check(rd == 8'hA5, "R4 old word A5", rd, 8'hA5);
    @(negedge clk);
    access(3, 0, 3, 0, 0, rd, cyc, gc);
    check(rd == 1, "R4 word overwritten", rd, 1);
  endtask

  task automatic t_tas_unlocked();
    int rd, cyc, gc;
    @(negedge clk);
    lock[3] = 1'b1;  // stray lock, no request (R9)
    access(0, 2, 9, 0, 0, rd, cyc, gc);
    check(rd == 0, "R5 returned word", rd, 0);
    check(cyc == 2, "R5 R9 single cycle", cyc, 2);
    check(gnt[3] == 1'b0, "R9 no grant for stray lock", int'(gnt[3]), 0);
    repeat (3) begin
      @(negedge clk);
      check(gnt == '0, "R9 bus stays idle", int'(gnt), 0);
    end
    lock[3] = 1'b0;
    access(1, 0, 9, 0, 0, rd, cyc, gc);
    check(rd == 0, "R5 word unchanged", rd, 0);
  endtask

  task automatic t_contend();
    int rd1, rd2, c1, c2, g1, g2, rd, cyc, gc;
    @(negedge clk);
    access(2, 0, 0, 0, 0, rd, cyc, gc);  // last granted = 2
    @(negedge clk);
    fork
      access(1, 2, 12, 0, 1, rd1, c1, g1);
      access(2, 2, 12, 0, 1, rd2, c2, g2);
    join
    check(rd1 == 0, "R8 R6 winner sees 0", rd1, 0);
    check(rd2 == 1, "R8 loser sees 1", rd2, 1);
    check(c2 == 6, "R8 R7 loser waits for locked pair and idle cycle", c2, 6);
    check(g1 == 2 && g2 == 2, "R8 grant cycles", g1 * 10 + g2, 22);
  endtask

  task automatic t_round_robin();
    int rd, cyc, gc, r0, r1, r2, r3, c0, c1, c2, c3, g0, g1, g2, g3;
    @(negedge clk);
    access(2, 0, 1, 0, 0, rd, cyc, gc);  // last granted = 2
    @(negedge clk);
    ord_n = 0;
    fork
      access(0, 0, 1, 0, 0, r0, c0, g0);
      access(1, 0, 1, 0, 0, r1, c1, g1);
      access(2, 0, 1, 0, 0, r2, c2, g2);
      access(3, 0, 1, 0, 0, r3, c3, g3);
    join
    check(ord_n == 4, "R6 grant count", ord_n, 4);
    check(ord[0] == 3, "R6 first", ord[0], 3);
    check(ord[1] == 0, "R6 second", ord[1], 0);
    check(ord[2] == 1, "R6 third", ord[2], 1);
    check(ord[3] == 2, "R6 fourth", ord[3], 2);
    @(negedge clk);
    ord_n = 0;
    fork
      access(2, 0, 1, 0, 0, r2, c2, g2);
      access(0, 0, 1, 0, 0, r0, c0, g0);
    join
    check(ord[0] == 0 && ord[1] == 2, "R6 pair order", ord[0] * 10 + ord[1], 2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_tas_locked();
    t_tas_unlocked();
    t_contend();
    t_round_robin();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule